// File: doc/BRIEF.md
# Memory-Image Test Pattern Sequencer

This block is a bus-master engine that applies stored test patterns to a device under verification. Two images sit in system memory: a stimulus image whose words are written into the device's register space, and a check image whose words are compared against what the device returns. Both images share one nested, pointer-based layout. Each image opens with a header, each block opens with a header, and each sequence opens with a header. The engine follows the pointers and needs no other description of the layout.

For each block index the engine first applies the stimulus block and then checks the matching result block, and it repeats this until every block has been used. A stimulus word is merged bitwise into the target register under its mask. A check word is XOR-compared with the register read-back, and its mask picks the bits that count. The engine records the first mismatch (register address, block index and the test word), keeps a sticky failure flag, and pulses done when the run ends.

The two base addresses are inputs, and a one-cycle start launches a run. The memory port and the device port both return read data one cycle after the read strobe.

Top module: `ims_sequencer`

## Requirements
- R1: A stimulus word whose mask is neither all zeros nor all ones is applied by read-modify-write. The engine reads register c and writes back n = (~m & c) | (m & v), so a bit keeps its current value wherever the mask bit is 0.
- R2: A stimulus word with an all-zeros mask causes no device read and no device write. When SKIP_FULL=1, a stimulus word with an all-ones mask is written as v with no read before it.
- R3: Every check word reads its register c and forms t = m & (c ^ v). Any 1 bit in t is a mismatch. Bits where m is 0 never cause a mismatch.
- R4: On the first mismatch of a run, the engine latches fail_addr (register), fail_blk (block index) and fail_t (the t word), and sets fail. Later mismatches overwrite none of these. An accepted start clears all of them.
- R5: While stop_on_fail is high, the first mismatch ends the run with the done pulse, and no later word or block is applied.
- R6: Blocks are processed in the order stimulus 0, check 0, stimulus 1, check 1, and so on, so check block i sees every write made by stimulus blocks 0..i.
- R7: Layout of an image: word 0 holds the block count N, and words 1..N hold the block pointers. Word N+1 holds the end pointer. A block's word 0 holds its sequence count S, and words 1..S hold the sequence pointers. A sequence's word 0 holds the first register address. The sequence's span runs up to the next sequence pointer; for the last sequence it runs to the next block pointer, or to the end pointer for the last block. With L = (span-1)/2, L values follow the header and then L masks, and they target consecutive registers.
- R8: If the two images hold different block counts, fmt_err is set, no device access is made and no done pulse appears. The next accepted start clears fmt_err.
- R9: done is a single-cycle pulse after the last check block. Images with zero blocks finish with one done pulse and no device access.
- R10: A device read and a device write never occur in the same cycle, and no device access happens while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a run when idle |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| in_base | input | AW | Base address of the stimulus image |
| out_base | input | AW | Base address of the check image |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | DW | Memory read data, one cycle after mem_rd |
| dev_rd | output | 1 | Device register read strobe |
| dev_wr | output | 1 | Device register write strobe |
| dev_addr | output | RAW | Device register address |
| dev_wdata | output | DW | Device register write data |
| dev_rdata | input | DW | Device read data, one cycle after dev_rd |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fmt_err | output | 1 | Block counts of the two images differ |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | RAW | Register of the first mismatch |
| fail_blk | output | AW | Block index of the first mismatch |
| fail_t | output | DW | Test word of the first mismatch |

## Verification
The bench builds the engine with DW=16, AW=8, RAW=4 and SKIP_FULL=1. The 256-word memory holds hand-placed images whose pointer spans exercise sequence lengths 1, 2 and 3 next to each other. The 16-register device lets successive blocks hit the same register, which makes the stimulus/check interleave visible at the ports. Because SKIP_FULL is on, the bench can tell the write-only path, the skipped word and the read-modify-write path apart by counting device reads and writes.

// File: rtl/ims_pkg.sv
package ims_pkg;
   typedef enum logic [4:0] {
      S_IDLE, S_IH0, S_IH1, S_BP, S_BPW, S_BEW, S_BHW, S_SP, S_SPW, S_SEW,
      S_SHW, S_RV, S_VW, S_MW, S_OP, S_CW, S_NW, S_NS, S_NB, S_FIN
   } ims_state_t;
endpackage

// File: rtl/ims_bitops.sv
module ims_bitops #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] cur,
   input  logic [DW-1:0] val,
   input  logic [DW-1:0] msk,
   output logic [DW-1:0] new_w,
   output logic [DW-1:0] test_w
);
   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign new_w[i]  = msk[i] ? val[i] : cur[i];
      assign test_w[i] = msk[i] & (cur[i] ^ val[i]);
   end
endmodule

// File: rtl/ims_fail_log.sv
module ims_fail_log #(
   parameter int DW  = 32,
   parameter int AW  = 16,
   parameter int RAW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           hit,
   input  logic [RAW-1:0] hit_addr,
   input  logic [AW-1:0]  hit_blk,
   input  logic [DW-1:0]  hit_t,
   output logic           fail,
   output logic [RAW-1:0] fail_addr,
   output logic [AW-1:0]  fail_blk,
   output logic [DW-1:0]  fail_t
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_blk  <= '0;
         fail_t    <= '0;
      end else if (clr) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_blk  <= '0;
         fail_t    <= '0;
      end else if (hit && !fail) begin
         fail      <= 1'b1;
         fail_addr <= hit_addr;
         fail_blk  <= hit_blk;
         fail_t    <= hit_t;
      end
   end
endmodule

// File: rtl/ims_sequencer.sv
module ims_sequencer
   import ims_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 16,
   parameter int RAW       = 8,
   parameter int SKIP_FULL = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           stop_on_fail,
   input  logic [AW-1:0]  in_base,
   input  logic [AW-1:0]  out_base,
   output logic           mem_rd,
   output logic [AW-1:0]  mem_addr,
   input  logic [DW-1:0]  mem_rdata,
   output logic           dev_rd,
   output logic           dev_wr,
   output logic [RAW-1:0] dev_addr,
   output logic [DW-1:0]  dev_wdata,
   input  logic [DW-1:0]  dev_rdata,
   output logic           busy,
   output logic           done,
   output logic           fmt_err,
   output logic           fail,
   output logic [RAW-1:0] fail_addr,
   output logic [AW-1:0]  fail_blk,
   output logic [DW-1:0]  fail_t
);
   localparam logic [AW-1:0]  A1 = AW'(1);
   localparam logic [AW-1:0]  A2 = AW'(2);
   localparam logic [RAW-1:0] R1 = RAW'(1);

   if (DW < 8)       begin : g_bad_dw  $error("DW must be at least 8"); end
   if (AW > DW)      begin : g_bad_aw  $error("AW must not exceed DW"); end
   if (RAW > DW)     begin : g_bad_raw $error("RAW must not exceed DW"); end
   if (RAW < 1)      begin : g_bad_r1  $error("RAW must be positive"); end

   ims_state_t     state;
   logic           sel;
   logic [AW-1:0]  in_b, out_b;
   logic [DW-1:0]  in_cnt;
   logic [AW-1:0]  blk_idx, blk_ptr, blk_end, nseq, seq_idx;
   logic [AW-1:0]  seq_ptr, seq_end, len, widx;
   logic [RAW-1:0] cur_reg;
   logic [DW-1:0]  val, msk, new_w, test_w;
   logic           full_skip, seq_last, hit, clr;

   wire [AW-1:0] rd_a   = mem_rdata[AW-1:0];
   wire [AW-1:0] img_b  = sel ? out_b : in_b;
   wire [AW-1:0] len_c  = (seq_end - seq_ptr - A1) >> 1;

   assign seq_last = (seq_idx == nseq - A1);
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_FIN);
   assign dev_addr = cur_reg;
   assign clr      = (state == S_IDLE) && start;
   assign hit      = (state == S_CW) && sel && (|test_w);

   if (SKIP_FULL != 0) begin : g_skip
      assign full_skip = &msk;
   end else begin : g_noskip
      assign full_skip = 1'b0;
   end

   ims_bitops #(.DW(DW)) u_ops (
      .cur(dev_rdata), .val(val), .msk(msk), .new_w(new_w), .test_w(test_w)
   );

   ims_fail_log #(.DW(DW), .AW(AW), .RAW(RAW)) u_log (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit),
      .hit_addr(cur_reg), .hit_blk(blk_idx), .hit_t(test_w),
      .fail(fail), .fail_addr(fail_addr), .fail_blk(fail_blk), .fail_t(fail_t)
   );

   always_comb begin
      mem_rd    = 1'b0;
      mem_addr  = '0;
      dev_rd    = 1'b0;
      dev_wr    = 1'b0;
      dev_wdata = val;
      case (state)
         S_IDLE: if (start) begin mem_rd = 1'b1; mem_addr = in_base; end
         S_IH0:  begin mem_rd = 1'b1; mem_addr = out_b; end
         S_BP:   begin mem_rd = 1'b1; mem_addr = img_b + A1 + blk_idx; end
         S_BPW:  begin mem_rd = 1'b1; mem_addr = img_b + A2 + blk_idx; end
         S_BEW:  begin mem_rd = 1'b1; mem_addr = blk_ptr; end
         S_SP:   begin mem_rd = 1'b1; mem_addr = blk_ptr + A1 + seq_idx; end
         S_SPW:  begin
            mem_rd   = 1'b1;
            mem_addr = seq_last ? rd_a : (blk_ptr + A2 + seq_idx);
         end
         S_SEW:  begin mem_rd = 1'b1; mem_addr = seq_ptr; end
         S_RV:   begin mem_rd = 1'b1; mem_addr = seq_ptr + A1 + widx; end
         S_VW:   begin mem_rd = 1'b1; mem_addr = seq_ptr + A1 + len + widx; end
         S_OP: begin
            if (sel)              dev_rd = 1'b1;
            else if (~|msk)       dev_rd = 1'b0;
            else if (full_skip)   dev_wr = 1'b1;
            else                  dev_rd = 1'b1;
         end
         S_CW: if (!sel) begin dev_wr = 1'b1; dev_wdata = new_w; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         sel     <= 1'b0;
         in_b    <= '0;
         out_b   <= '0;
         in_cnt  <= '0;
         blk_idx <= '0;
         blk_ptr <= '0;
         blk_end <= '0;
         nseq    <= '0;
         seq_idx <= '0;
         seq_ptr <= '0;
         seq_end <= '0;
         len     <= '0;
         widx    <= '0;
         cur_reg <= '0;
         val     <= '0;
         msk     <= '0;
         fmt_err <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               in_b    <= in_base;
               out_b   <= out_base;
               fmt_err <= 1'b0;
               state   <= S_IH0;
            end
            S_IH0: begin
               in_cnt <= mem_rdata;
               state  <= S_IH1;
            end
            S_IH1: begin
               sel     <= 1'b0;
               blk_idx <= '0;
               if (mem_rdata != in_cnt) begin
                  fmt_err <= 1'b1;
                  state   <= S_IDLE;
               end else if (in_cnt == '0) state <= S_FIN;
               else                       state <= S_BP;
            end
            S_BP:  state <= S_BPW;
            S_BPW: begin blk_ptr <= rd_a; state <= S_BEW; end
            S_BEW: begin blk_end <= rd_a; state <= S_BHW; end
            S_BHW: begin
               nseq    <= rd_a;
               seq_idx <= '0;
               state   <= (rd_a == '0) ? S_NB : S_SP;
            end
            S_SP:  state <= S_SPW;
            S_SPW: begin
               seq_ptr <= rd_a;
               if (seq_last) begin
                  seq_end <= blk_end;
                  state   <= S_SHW;
               end else state <= S_SEW;
            end
            S_SEW: begin seq_end <= rd_a; state <= S_SHW; end
            S_SHW: begin
               cur_reg <= mem_rdata[RAW-1:0];
               len     <= len_c;
               widx    <= '0;
               state   <= (len_c == '0) ? S_NS : S_RV;
            end
            S_RV:  state <= S_VW;
            S_VW:  begin val <= mem_rdata; state <= S_MW; end
            S_MW:  begin msk <= mem_rdata; state <= S_OP; end
            S_OP: begin
               if (!sel && ((~|msk) || full_skip)) state <= S_NW;
               else                                 state <= S_CW;
            end
            S_CW:  state <= (hit && stop_on_fail) ? S_FIN : S_NW;
            S_NW: begin
               if (widx == len - A1) state <= S_NS;
               else begin
                  widx    <= widx + A1;
                  cur_reg <= cur_reg + R1;
                  state   <= S_RV;
               end
            end
            S_NS: begin
               if (seq_last) state <= S_NB;
               else begin
                  seq_idx <= seq_idx + A1;
                  state   <= S_SP;
               end
            end
            S_NB: begin
               if (!sel) begin
                  sel   <= 1'b1;
                  state <= S_BP;
               end else if ({{(DW-AW){1'b0}}, blk_idx} == in_cnt - DW'(1)) begin
                  state <= S_FIN;
               end else begin
                  sel     <= 1'b0;
                  blk_idx <= blk_idx + A1;
                  state   <= S_BP;
               end
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ims_sequencer_chk.sv
module ims_sequencer_chk #(
   parameter int RAW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           fail,
   input logic           fmt_err,
   input logic           dev_rd,
   input logic           dev_wr,
   input logic [RAW-1:0] fail_addr
);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_dev_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr));
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dev_rd && !dev_wr));
   a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail);
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> $stable(fail_addr));
   a_r8_fmt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> (!dev_rd && !dev_wr && !done));
endmodule

bind ims_sequencer ims_sequencer_chk #(.RAW(RAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .fmt_err(fmt_err), .dev_rd(dev_rd), .dev_wr(dev_wr),
   .fail_addr(fail_addr)
);

// File: tb/sim_ims_sequencer.sv
module sim_ims_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16, AW = 8, RAW = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop_on_fail = 1'b0;
   logic [AW-1:0] in_base = '0, out_base = 8'd64;
   logic mem_rd, dev_rd, dev_wr, busy, done, fmt_err, fail;
   logic [AW-1:0] mem_addr, fail_blk;
   logic [DW-1:0] mem_rdata, dev_wdata, dev_rdata, fail_t;
   logic [RAW-1:0] dev_addr, fail_addr;

   logic [DW-1:0] mem [256];
   logic [DW-1:0] dregs [16];
   int rd_cnt = 0, wr_cnt = 0;
   int total = 0, bad = 0;
   int ndone, rd_d, wr_d;

   always #(CLK_PERIOD/2) clk = ~clk;

   ims_sequencer #(.DW(DW), .AW(AW), .RAW(RAW), .SKIP_FULL(1)) u0 (.*);

   always @(posedge clk) begin
      mem_rdata <= mem[mem_addr];
      dev_rdata <= dregs[dev_addr];
      if (dev_wr) dregs[dev_addr] <= dev_wdata;
      if (dev_rd) rd_cnt <= rd_cnt + 1;
      if (dev_wr) wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic fill_regs(input logic [DW-1:0] v);
      for (int i = 0; i < 16; i++) dregs[i] = v;
   endtask

   task automatic img1(input int b, input int r, input int len,
                       input logic [DW-1:0] v0, m0, v1, m1);
      mem[b] = 1; mem[b+1] = DW'(b+3); mem[b+2] = DW'(b+6+2*len);
      mem[b+3] = 1; mem[b+4] = DW'(b+5); mem[b+5] = DW'(r);
      if (len == 1) begin mem[b+6] = v0; mem[b+7] = m0; end
      else begin mem[b+6] = v0; mem[b+7] = v1; mem[b+8] = m0; mem[b+9] = m1; end
   endtask

   task automatic img2(input int b, input int r0, input logic [DW-1:0] v0, m0,
                       input int r1, input logic [DW-1:0] v1, m1);
      mem[b] = 2; mem[b+1] = DW'(b+4); mem[b+2] = DW'(b+9); mem[b+3] = DW'(b+14);
      mem[b+4] = 1; mem[b+5] = DW'(b+6);
      mem[b+6] = DW'(r0); mem[b+7] = v0; mem[b+8] = m0;
      mem[b+9] = 1; mem[b+10] = DW'(b+11);
      mem[b+11] = DW'(r1); mem[b+12] = v1; mem[b+13] = m1;
   endtask

   task automatic run(input logic stop);
      int rd0, wr0;
      bit ok;
      rd0 = rd_cnt; wr0 = wr_cnt; ok = 1'b0;
      @(negedge clk); start = 1'b1; stop_on_fail = stop;
      @(negedge clk); start = 1'b0;
      ndone = 0;
      for (int i = 0; i < 3000; i++) begin
         if (done) ndone++;
         if (!busy) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) chk("run hung", 0, 1);
      rd_d = rd_cnt - rd0; wr_d = wr_cnt - wr0;
   endtask

   task automatic t_reset;
      chk("R9 reset done", done, 0);
      chk("R10 reset busy", busy, 0);
      chk("R4 reset fail", fail, 0);
      chk("R8 reset fmt_err", fmt_err, 0);
   endtask

   task automatic t_basic;
      fill_regs(16'h0000); dregs[2] = 16'h1234; dregs[3] = 16'hABCD;
      img1(0, 2, 2, 16'h5678, 16'h00FF, 16'h0F0F, 16'hF0F0);
      img1(64, 2, 2, 16'hED78, 16'h00FF, 16'h0B0D, 16'hFFFF);
      run(1'b0);
      chk("R1 merge reg2", dregs[2], 16'h1278);
      chk("R1 merge reg3", dregs[3], 16'h0B0D);
      chk("R1 rmw reads", rd_d, 4);
      chk("R1 rmw writes", wr_d, 2);
      chk("R3 dont-care bits pass", fail, 0);
      chk("R9 single done", ndone, 1);
   endtask

   task automatic t_fail;
      fill_regs(16'h0000); dregs[2] = 16'h1234; dregs[3] = 16'hABCD;
      img1(0, 2, 2, 16'h5678, 16'h00FF, 16'h0F0F, 16'hF0F0);
      img1(64, 2, 2, 16'h1279, 16'h000F, 16'h0B0E, 16'h00FF);
      run(1'b0);
      chk("R3 mismatch flagged", fail, 1);
      chk("R4 first addr", fail_addr, 2);
      chk("R4 first t", fail_t, 16'h0001);
      chk("R4 first blk", fail_blk, 0);
      chk("R4 run continues", ndone, 1);
      t_basic();
      chk("R4 cleared by start", fail, 0);
   endtask

   task automatic t_skip;
      fill_regs(16'h0000); dregs[4] = 16'h1357; dregs[5] = 16'h2468;
      img1(0, 4, 2, 16'hFFFF, 16'h0000, 16'hAAAA, 16'hFFFF);
      img1(64, 4, 1, 16'h0000, 16'h0000, 16'h0, 16'h0);
      run(1'b0);
      chk("R2 zero mask untouched", dregs[4], 16'h1357);
      chk("R2 full mask written", dregs[5], 16'hAAAA);
      chk("R2 reads only from check", rd_d, 1);
      chk("R2 single write", wr_d, 1);
   endtask

   task automatic t_seqlen;
      fill_regs(16'hEEEE);
      mem[0] = 1; mem[1] = 3; mem[2] = 16;
      mem[3] = 2; mem[4] = 6; mem[5] = 9;
      mem[6] = 8; mem[7] = 16'h0011; mem[8] = 16'hFFFF;
      mem[9] = 10; mem[10] = 16'h00A0; mem[11] = 16'h00A1; mem[12] = 16'h00A2;
      mem[13] = 16'hFFFF; mem[14] = 16'hFFFF; mem[15] = 16'hFFFF;
      img1(64, 10, 1, 16'h00A0, 16'hFFFF, 16'h0, 16'h0);
      run(1'b0);
      chk("R7 len1 reg8", dregs[8], 16'h0011);
      chk("R7 len1 stops reg9", dregs[9], 16'hEEEE);
      chk("R7 len3 reg10", dregs[10], 16'h00A0);
      chk("R7 len3 reg11", dregs[11], 16'h00A1);
      chk("R7 len3 reg12", dregs[12], 16'h00A2);
      chk("R7 len3 stops reg13", dregs[13], 16'hEEEE);
      chk("R7 check passes", fail, 0);
   endtask

   task automatic t_alternate;
      fill_regs(16'h0000);
      img2(0, 7, 16'h0005, 16'hFFFF, 7, 16'h0009, 16'hFFFF);
      img2(64, 7, 16'h0005, 16'hFFFF, 7, 16'h0009, 16'hFFFF);
      run(1'b0);
      chk("R6 interleave passes", fail, 0);
      chk("R6 final reg7", dregs[7], 16'h0009);
      img2(64, 7, 16'h0005, 16'hFFFF, 7, 16'h000A, 16'hFFFF);
      run(1'b0);
      chk("R6 blk1 mismatch", fail, 1);
      chk("R6 fail blk index", fail_blk, 1);
      chk("R6 fail t", fail_t, 16'h0003);
   endtask

   task automatic t_stop;
      fill_regs(16'h0000);
      img2(0, 2, 16'h1111, 16'hFFFF, 5, 16'h5555, 16'hFFFF);
      img2(64, 2, 16'h2222, 16'hFFFF, 5, 16'h5555, 16'hFFFF);
      run(1'b1);
      chk("R5 stop fail", fail, 1);
      chk("R5 stop blk", fail_blk, 0);
      chk("R5 later block not applied", dregs[5], 16'h0000);
      chk("R5 stop done", ndone, 1);
      fill_regs(16'h0000);
      run(1'b0);
      chk("R5 no stop applies blk1", dregs[5], 16'h5555);
      chk("R5 no stop done", ndone, 1);
   endtask

   task automatic t_format;
      int rd0, wr0;
      mem[0] = 1; mem[64] = 2;
      run(1'b0);
      chk("R8 fmt_err set", fmt_err, 1);
      chk("R8 no done", ndone, 0);
      chk("R8 no device access", rd_d + wr_d, 0);
      mem[0] = 0; mem[64] = 0;
      run(1'b0);
      chk("R8 fmt_err cleared", fmt_err, 0);
      chk("R9 empty done", ndone, 1);
      chk("R9 empty no access", rd_d + wr_d, 0);
      rd0 = rd_cnt; wr0 = wr_cnt;
      repeat (5) @(negedge clk);
      chk("R10 idle quiet", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      fill_regs(16'h0000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_fail();
      t_skip();
      t_seqlen();
      t_alternate();
      t_stop();
      t_format();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule